// File: doc/BRIEF.md
# Embedded-Sync Video Input Decoder

This block sits behind an external TV decoder chip and takes its digital YCbCr output, either as one 8-bit lane that carries luma and chroma bytes in turn (double-rate sampling) or as two 8-bit lanes that carry luma and chroma side by side (single-rate sampling). The video carries no separate sync wires. Timing is embedded in the stream as four-symbol reference codes. The block finds those codes and checks each one for errors. From them it rebuilds horizontal sync, vertical blanking, field identity and an active-data strobe that travels with the pixel word.

Each kind of timing event also sets a sticky flag in a status byte that a host polls. Any write strobe from the host clears every flag at once. A level control input clears them as well, and holds them clear for as long as it stays high. The input bus can be captured on either clock edge. Sync decoding can be switched off.

Top module: `vid_sync_decoder`

## Requirements
- R1: When `cfg_neg_edge` is 0 the input bus is captured on the rising clock edge, and when it is 1 it is captured on the falling edge. Data valid only around the other edge is never decoded.
- R2: When `cfg_dbl_rate` is 1, one symbol per clock is taken from `vin_data[7:0]` and the upper lane is ignored. When it is 0, timing codes are taken from the luma lane `vin_data[15:8]` and the chroma lane `vin_data[7:0]` travels with it.
- R3: A timing code is the symbol run 0xFF, 0x00, 0x00, XY with XY[7]=1, XY[6]=F, XY[5]=V and XY[4]=H (0 marks start of active video, 1 marks end). `hs_out` goes high on an end code and low on a start code. `vs_out` and `fld_out` follow V and F of the latest valid code.
- R4: `stat_q` holds sticky flags: bit 6 start code, bit 5 end code, bit 4 ancillary preamble, bit 3 task (a start code with V=1), bit 2 field (a code with F=1), bit 1 horizontal sync (an end code), bit 0 vertical sync (a code with V=1). Bit 7 always reads 0.
- R5: A pulse on `host_wr` clears every status flag on the next clock edge.
- R6: While `cfg_stat_clr` is high, every status flag is held at 0 and no event sets it.
- R7: XY[3:0] must equal {V^H, F^H, F^V, F^V^H}. A code that fails this check changes neither the sync outputs nor the status flags.
- R8: `act_out` is high for exactly the samples that lie strictly between a start code and the next end code while V is 0. The four code symbols themselves are never strobed.
- R9: The symbol run 0x00, 0xFF, 0xFF sets the ancillary flag.
- R10: While `cfg_dec_en` is 0 no codes are detected, so the sync outputs and the status flags keep their values.
- R11: `pix_out` carries the sample that `act_out` marks. In double-rate mode it is {0x00, symbol}; in single-rate mode it is {luma, chroma}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Video sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_neg_edge | input | 1 | Capture edge: 0 rising, 1 falling |
| cfg_dbl_rate | input | 1 | 1: 8-bit multiplexed lane; 0: 16-bit parallel lanes |
| cfg_dec_en | input | 1 | Enable for timing-code detection |
| cfg_stat_clr | input | 1 | Level clear of all status flags |
| host_wr | input | 1 | Status register write strobe; clears all flags |
| vin_data | input | 16 | Video input bus |
| hs_out | output | 1 | Recovered horizontal sync |
| vs_out | output | 1 | Recovered vertical blanking |
| fld_out | output | 1 | Recovered field identity |
| act_out | output | 1 | Active-data strobe for `pix_out` |
| pix_out | output | 16 | Pixel word aligned with `act_out` |
| stat_q | output | 8 | Sticky status flags |

## Verification
The hardest case to reach from the ports is a capture edge that does not match the data timing, because a bench that holds each word for a whole clock hides the edge choice completely. To expose it, the stimulus drives the real symbol only in the half-period around the intended edge and drives a decoy value (0x5A) in the other half. A correct capture edge then decodes a full line, and a wrong one sees only decoys. A second case that needs care is an end code inside active video. Its first three symbols look like pixels until the fourth arrives. The bench therefore counts strobes over whole lines, and a strobe on the 0xFF or 0x00 of a code shows up as an excess in that count.

// File: rtl/vid_sync_decoder.sv
module vid_sync_decoder #(
  parameter int LW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_neg_edge,
  input  logic            cfg_dbl_rate,
  input  logic            cfg_dec_en,
  input  logic            cfg_stat_clr,
  input  logic            host_wr,
  input  logic [2*LW-1:0] vin_data,
  output logic            hs_out,
  output logic            vs_out,
  output logic            fld_out,
  output logic            act_out,
  output logic [2*LW-1:0] pix_out,
  output logic [7:0]      stat_q
);
  localparam int BW = 2 * LW;
  localparam logic [LW-1:0] ONES = {LW{1'b1}};
  localparam logic [LW-1:0] ZERO = '0;

  logic [BW-1:0] cap_p, cap_n;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cap_p <= '0;
    else        cap_p <= vin_data;
  always_ff @(negedge clk or negedge rst_n)
    if (!rst_n) cap_n <= '0;
    else        cap_n <= vin_data;

  logic [BW-1:0] word, pw;
  logic [LW-1:0] sym;
  assign word = cfg_neg_edge ? cap_n : cap_p;
  assign sym  = cfg_dbl_rate ? word[LW-1:0] : word[BW-1:LW];
  assign pw   = cfg_dbl_rate ? {{LW{1'b0}}, word[LW-1:0]} : word;

  logic [LW-1:0] d0, d1, d2;
  logic [BW-1:0] w0, w1, w2;
  logic t0, t1, t2;
  logic in_line, vb_q, fd_q, hs_q;

  logic [7:0] xy;
  logic fb, vb, hb, prot_ok, prefix, code_ok, anc_hit, act_state;
  assign xy      = sym[LW-1 -: 8];
  assign fb      = xy[6];
  assign vb      = xy[5];
  assign hb      = xy[4];
  assign prot_ok = xy[3:0] == {vb ^ hb, fb ^ hb, fb ^ vb, fb ^ vb ^ hb};
  assign prefix  = d2 == ONES && d1 == ZERO && d0 == ZERO;
  assign code_ok = cfg_dec_en && prefix && xy[7] && prot_ok;
  assign anc_hit = cfg_dec_en && d1 == ZERO && d0 == ONES && sym == ONES;
  assign act_state = in_line & ~vb_q;

  logic [7:0] set_v;
  assign set_v = {1'b0,
                  code_ok & ~hb,
                  code_ok & hb,
                  anc_hit,
                  code_ok & ~hb & vb,
                  code_ok & fb,
                  code_ok & hb,
                  code_ok & vb};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      d0 <= '0; d1 <= '0; d2 <= '0;
      w0 <= '0; w1 <= '0; w2 <= '0;
      t0 <= 1'b0; t1 <= 1'b0; t2 <= 1'b0;
      act_out <= 1'b0;
      pix_out <= '0;
    end else begin
      d0 <= sym; d1 <= d0; d2 <= d1;
      w0 <= pw;  w1 <= w0; w2 <= w1;
      t0 <= act_state & ~code_ok;
      t1 <= t0 & ~code_ok;
      t2 <= t1 & ~code_ok;
      act_out <= t2 & ~code_ok;
      pix_out <= w2;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      in_line <= 1'b0; vb_q <= 1'b0; fd_q <= 1'b0; hs_q <= 1'b0;
    end else if (code_ok) begin
      in_line <= ~hb;
      hs_q    <= hb;
      vb_q    <= vb;
      fd_q    <= fb;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                      stat_q <= '0;
    else if (host_wr | cfg_stat_clr) stat_q <= '0;
    else                             stat_q <= stat_q | set_v;

  assign hs_out  = hs_q;
  assign vs_out  = vb_q;
  assign fld_out = fd_q;
endmodule

module vid_sync_decoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_dec_en,
  input logic       cfg_stat_clr,
  input logic       host_wr,
  input logic       hs_out,
  input logic [7:0] stat_q
);
  assert_bit7_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    stat_q[7] == 1'b0);
  assert_wr_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr |=> stat_q == 8'h00);
  assert_lvl_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_stat_clr |=> stat_q == 8'h00);
  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_dec_en && !host_wr && !cfg_stat_clr) |=> $stable(stat_q) && $stable(hs_out));
  assert_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_wr && !cfg_stat_clr) |=> (stat_q & $past(stat_q)) == $past(stat_q));
  assert_hs_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(hs_out) && !$past(host_wr) && !$past(cfg_stat_clr)) |-> stat_q[5] && stat_q[1]);
endmodule

bind vid_sync_decoder vid_sync_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_dec_en(cfg_dec_en), .cfg_stat_clr(cfg_stat_clr),
  .host_wr(host_wr), .hs_out(hs_out), .stat_q(stat_q)
);

// File: tb/sim_vid_sync_decoder.sv
module sim_vid_sync_decoder;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_neg_edge = 1'b0, cfg_dbl_rate = 1'b1, cfg_dec_en = 1'b1;
  logic cfg_stat_clr = 1'b0, host_wr = 1'b0;
  logic [15:0] vin_data = 16'h1010;
  logic hs_out, vs_out, fld_out, act_out;
  logic [15:0] pix_out;
  logic [7:0] stat_q;

  int checks = 0, errors = 0;
  int act_cnt = 0;
  logic [15:0] first_pix = '0;
  logic align_neg = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vid_sync_decoder u0 (
    .clk(clk), .rst_n(rst_n), .cfg_neg_edge(cfg_neg_edge), .cfg_dbl_rate(cfg_dbl_rate),
    .cfg_dec_en(cfg_dec_en), .cfg_stat_clr(cfg_stat_clr), .host_wr(host_wr),
    .vin_data(vin_data), .hs_out(hs_out), .vs_out(vs_out), .fld_out(fld_out),
    .act_out(act_out), .pix_out(pix_out), .stat_q(stat_q)
  );

  always @(negedge clk) if (act_out) begin
    if (act_cnt == 0) first_pix = pix_out;
    act_cnt = act_cnt + 1;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] xyb(input logic f, input logic v, input logic h, input logic bad);
    return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, (f ^ v ^ h) ^ bad};
  endfunction

  task automatic send_word(input logic [15:0] w);
    @(posedge clk); #1 vin_data = align_neg ? w : 16'h5A5A;
    @(negedge clk); #1 vin_data = align_neg ? 16'h5A5A : w;
  endtask

  task automatic sym(input logic [7:0] s);
    send_word(cfg_dbl_rate ? {8'hA5, s} : {s, 8'h80});
  endtask

  task automatic fill(input int n);
    for (int i = 0; i < n; i++) sym(8'h10);
  endtask

  task automatic code(input logic f, input logic v, input logic h, input logic bad);
    sym(8'hFF); sym(8'h00); sym(8'h00); sym(xyb(f, v, h, bad));
  endtask

  task automatic host_clear();
    @(posedge clk); #1 host_wr = 1'b1;
    @(posedge clk); #1 host_wr = 1'b0;
  endtask

  task automatic line(input logic f, input logic v, input int n, input logic [7:0] base);
    fill(4);
    code(f, v, 1'b1, 1'b0);
    fill(4);
    code(f, v, 1'b0, 1'b0);
    for (int i = 0; i < n; i++) sym(base + 8'(i));
    code(f, v, 1'b1, 1'b0);
    fill(8);
  endtask

  task automatic t_reset();
    check("R4 reset stat", stat_q, 8'h00);
    check("R3 reset sync", {hs_out, vs_out, fld_out, act_out}, 4'b0000);
  endtask

  task automatic t_basic_dbl();
    cfg_dbl_rate = 1'b1; cfg_neg_edge = 1'b0; align_neg = 1'b0;
    fill(4); host_clear(); act_cnt = 0;
    fill(4); code(0, 0, 1, 0); fill(2);
    check("R3 hs high after end code", hs_out, 1'b1);
    code(0, 0, 0, 0); sym(8'h20); sym(8'h21); sym(8'h22); fill(0);
    check("R3 hs low after start code", hs_out, 1'b0);
    for (int i = 3; i < 8; i++) sym(8'h20 + 8'(i));
    code(0, 0, 1, 0); fill(8);
    check("R8 strobe count dbl", act_cnt, 8);
    check("R11 first pixel dbl", first_pix, 16'h0020);
    check("R4 flags plain line", stat_q, 8'h62);
    check("R3 vs/fld", {vs_out, fld_out}, 2'b00);
  endtask

  task automatic t_vblank_field();
    host_clear(); act_cnt = 0;
    line(0, 1, 6, 8'h30);
    check("R8 no strobe in blanking", act_cnt, 0);
    check("R3 vs follows V", vs_out, 1'b1);
    check("R4 task/vsync flags", stat_q, 8'h6B);
    host_clear(); act_cnt = 0;
    line(1, 0, 5, 8'h40);
    check("R3 fld follows F", {fld_out, vs_out}, 2'b10);
    check("R4 field flag", stat_q, 8'h66);
    check("R8 strobe count field 1", act_cnt, 5);
  endtask

  task automatic t_protection();
    fill(2); code(0, 0, 0, 0); fill(4);
    host_clear();
    code(0, 0, 1, 1); fill(6);
    check("R7 bad code no flags", stat_q, 8'h00);
    check("R7 bad code no hs", hs_out, 1'b0);
    code(0, 1, 1, 1); fill(4);
    check("R7 bad code no vs", vs_out, 1'b0);
    code(0, 0, 1, 0); fill(4);
  endtask

  task automatic t_anc();
    host_clear();
    fill(2); sym(8'h00); sym(8'hFF); sym(8'hFF); fill(4);
    check("R9 ancillary flag", stat_q, 8'h10);
  endtask

  task automatic t_clears();
    line(0, 0, 3, 8'h50);
    check("R5 flags before write", stat_q != 8'h00, 1'b1);
    host_clear();
    check("R5 write clears", stat_q, 8'h00);
    @(posedge clk); #1 cfg_stat_clr = 1'b1;
    line(1, 1, 3, 8'h50);
    check("R6 held clear", stat_q, 8'h00);
    @(posedge clk); #1 cfg_stat_clr = 1'b0;
    fill(2); code(0, 0, 1, 0); fill(4);
    check("R6 sets after release", stat_q, 8'h22);
    check("R4 bit7 zero", stat_q[7], 1'b0);
  endtask

  task automatic t_disable();
    fill(2); code(0, 0, 0, 0); fill(4);
    host_clear();
    cfg_dec_en = 1'b0; act_cnt = 0;
    code(1, 1, 1, 0); sym(8'h00); sym(8'hFF); sym(8'hFF); fill(6);
    check("R10 no flags when off", stat_q, 8'h00);
    check("R10 sync held", {hs_out, vs_out, fld_out}, 3'b000);
    cfg_dec_en = 1'b1;
    fill(2); code(0, 0, 1, 0); fill(8);
  endtask

  task automatic t_edges();
    cfg_neg_edge = 1'b1; align_neg = 1'b1;
    fill(4); host_clear(); act_cnt = 0;
    line(0, 0, 7, 8'h60);
    check("R1 falling edge count", act_cnt, 7);
    check("R1 falling edge flags", stat_q, 8'h62);
    cfg_neg_edge = 1'b0; align_neg = 1'b1;
    fill(4); host_clear(); act_cnt = 0;
    line(0, 0, 7, 8'h60);
    check("R1 wrong edge no flags", stat_q, 8'h00);
    check("R1 wrong edge no strobe", act_cnt, 0);
    cfg_neg_edge = 1'b0; align_neg = 1'b0;
    fill(4);
  endtask

  task automatic t_single_rate();
    cfg_dbl_rate = 1'b0;
    fill(4); host_clear(); act_cnt = 0;
    line(0, 0, 9, 8'h70);
    check("R2 single-rate strobe count", act_cnt, 9);
    check("R11 first pixel single-rate", first_pix, 16'h7080);
    check("R2 single-rate flags", stat_q, 8'h62);
    cfg_dbl_rate = 1'b1;
    fill(4);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic_dbl();
    t_vblank_field();
    t_protection();
    t_anc();
    t_clears();
    t_disable();
    t_edges();
    t_single_rate();
    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end
endmodule